// File: doc/BRIEF.md
# Temperature-Indexed Supply Voltage Controller

This block picks a supply-voltage code for the regulator from the die temperature. Below the inversion voltage, logic runs faster when it is warmer. A warmer die therefore needs less supply to meet the same timing margin that the cold corner needs. The block keeps one small lookup table for each clock frequency. Each table entry holds an upper temperature bound and a voltage code. The currently selected frequency picks which table is searched.

Every voltage code is a count of 6.25 mV regulator steps, so code 112 is 0.7 V and code 104 is 0.65 V. A programmable divider sets the update rate, normally a period of about a millisecond. On each update strobe the block re-evaluates the temperature range and moves its output code at most one step toward the target. A hysteresis band stops the range from flapping at a boundary. When the temperature reading is marked invalid, the block falls back to the coldest-range entry.

Top module: `tvc_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `volt_code` and `volt_tgt` both equal RESET_CODE (default 112).
- R2: The update strobe fires once every `tick_div`+1 clock cycles. `volt_code` changes only on a strobe, so consecutive steps of a long slew are exactly `tick_div`+1 cycles apart.
- R3: On each strobe `volt_code` moves exactly one code (6.25 mV) toward `volt_tgt`, and never away from it.
- R4: Range k is the lowest index whose stored upper bound is greater than or equal to the temperature. A temperature above every bound selects the last range, index NRANGE-1. The entry at range k supplies the target.
- R5: `freq_sel` chooses the table, and the same range index reads that table's entry.
- R6: Neither `volt_tgt` nor `volt_code` ever goes below FLOOR_CODE (default 104, 0.65 V). A stored code below the floor yields the floor as the target.
- R7: A move to a higher range happens only when the temperature is at least the current range's bound + 1 + `hyst_band`. A move to a lower range happens only when the temperature + `hyst_band` is at most the bound of the range just below the current one.
- R8: While `temp_valid` is low, the target is range 0 of the active table and the range index is held. Once `temp_valid` rises again, range evaluation resumes from the held index.
- R9: A write with `wr_en` stores `wr_bound` and `wr_code` at table `wr_freq`, entry `wr_idx`. A change to the entry in use changes the target on the next strobe.
- R10: Once `volt_code` equals `volt_tgt` it stays constant for as long as the target does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_div | input | TICK_W | Update period minus one, in clock cycles |
| hyst_band | input | HYST_W | Hysteresis in temperature units |
| temp | input | TEMP_W | Digitized die temperature |
| temp_valid | input | 1 | Temperature reading is trustworthy |
| freq_sel | input | FREQ_W | Active frequency, selects the table |
| wr_en | input | 1 | Table write strobe |
| wr_freq | input | FREQ_W | Table written |
| wr_idx | input | IDX_W | Entry written |
| wr_bound | input | TEMP_W | Upper temperature bound of the entry |
| wr_code | input | VCODE_W | Voltage code of the entry |
| volt_code | output | VCODE_W | Code sent to the regulator |
| volt_tgt | output | VCODE_W | Current target code |

## Verification
A corrupted range index shows up on `volt_tgt` within one strobe period as a code from the wrong table row. The hysteresis and invalid-hold checks catch this, because their expected codes differ from what a freshly evaluated range would produce. A slewer that skips steps or moves the wrong way shows on `volt_code` at the first strobe after the fault, and the step monitor counts it. A miscounting divider changes the spacing between consecutive steps, which is measured in cycles during a 34-step slew.

// File: rtl/tvc_pkg.sv
// Shared types and helpers for the temperature-indexed voltage controller.
// Assumes codes are unsigned counts of regulator steps.
package tvc_pkg;

    typedef enum logic [1:0] {
        SLEW_HOLD = 2'd0,
        SLEW_UP   = 2'd1,
        SLEW_DOWN = 2'd2
    } slew_dir_e;

    // Pick the direction that moves cur toward tgt.
    function automatic slew_dir_e slew_dir(input logic [15:0] cur, input logic [15:0] tgt);
        if (tgt > cur)      return SLEW_UP;
        else if (tgt < cur) return SLEW_DOWN;
        else                return SLEW_HOLD;
    endfunction

endpackage

// File: rtl/tvc_tick_gen.sv
// Update-strobe divider: pulses tick for one cycle every div+1 cycles.
// Assumes div may change at any time; an overshot count restarts at zero.
module tvc_tick_gen #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] div,
    output logic              tick
);
    logic [TICK_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    // Count cycles and wrap when the strobe fires.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tvc_table.sv
// Per-frequency range table: each entry holds an upper temperature bound and
// a voltage code. Exposes every bound of the read table, the code at the
// read index, and the code of range 0 (the cold fallback).
// Assumes entries are written in order of rising bound by the loader.
module tvc_table #(
    parameter int NFREQ      = 4,
    parameter int NRANGE     = 8,
    parameter int TEMP_W     = 8,
    parameter int VCODE_W    = 8,
    parameter int RESET_CODE = 112,
    localparam int FREQ_W    = (NFREQ  > 1) ? $clog2(NFREQ)  : 1,
    localparam int IDX_W     = (NRANGE > 1) ? $clog2(NRANGE) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [FREQ_W-1:0]        wr_freq,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [TEMP_W-1:0]        wr_bound,
    input  logic [VCODE_W-1:0]       wr_code,
    input  logic [FREQ_W-1:0]        rd_freq,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [NRANGE*TEMP_W-1:0] rd_bounds,
    output logic [VCODE_W-1:0]       rd_code,
    output logic [VCODE_W-1:0]       rd_cold_code
);
    logic [TEMP_W-1:0]  bound_q [NFREQ][NRANGE];
    logic [VCODE_W-1:0] code_q  [NFREQ][NRANGE];

    generate
        for (genvar f = 0; f < NFREQ; f++) begin : g_freq
            for (genvar r = 0; r < NRANGE; r++) begin : g_rng
                // Hold one entry; load it on a matching write.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        bound_q[f][r] <= '1;
                        code_q[f][r]  <= VCODE_W'(RESET_CODE);
                    end else if (wr_en && (int'(wr_freq) == f) && (int'(wr_idx) == r)) begin
                        bound_q[f][r] <= wr_bound;
                        code_q[f][r]  <= wr_code;
                    end
                end
                // Flatten the bounds of the read table.
                assign rd_bounds[r*TEMP_W +: TEMP_W] = bound_q[rd_freq][r];
            end
        end
    endgenerate

    assign rd_code      = code_q[rd_freq][rd_idx];
    assign rd_cold_code = code_q[rd_freq][0];
endmodule

// File: rtl/tvc_range_sel.sv
// Temperature range tracker with hysteresis. On each tick with a valid
// temperature, finds the lowest range whose bound covers the reading and
// accepts it only if the reading clears the boundary by the hysteresis band.
// Assumes the bounds rise with the range index.
module tvc_range_sel #(
    parameter int NRANGE  = 8,
    parameter int TEMP_W  = 8,
    parameter int HYST_W  = 4,
    localparam int IDX_W  = (NRANGE > 1) ? $clog2(NRANGE) : 1,
    localparam int SUM_W  = ((TEMP_W > HYST_W) ? TEMP_W : HYST_W) + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     temp_valid,
    input  logic [TEMP_W-1:0]        temp,
    input  logic [HYST_W-1:0]        hyst,
    input  logic [NRANGE*TEMP_W-1:0] bounds,
    output logic [IDX_W-1:0]         range_q
);
    logic [IDX_W-1:0] raw_idx;
    logic [SUM_W-1:0] temp_w, hyst_w, cur_bound_w, low_bound_w;
    logic             go_up, go_down;

    // Lowest range whose bound is at or above the reading.
    always_comb begin
        raw_idx = IDX_W'(NRANGE - 1);
        for (int i = NRANGE - 1; i >= 0; i--) begin
            if (temp <= bounds[i*TEMP_W +: TEMP_W]) raw_idx = IDX_W'(i);
        end
    end

    // Boundary tests against the current range, widened to avoid overflow.
    always_comb begin
        temp_w      = SUM_W'(temp);
        hyst_w      = SUM_W'(hyst);
        cur_bound_w = SUM_W'(bounds[int'(range_q)*TEMP_W +: TEMP_W]);
        low_bound_w = '0;
        if (range_q != '0)
            low_bound_w = SUM_W'(bounds[(int'(range_q) - 1)*TEMP_W +: TEMP_W]);
        go_up   = (raw_idx > range_q) && (temp_w >= cur_bound_w + hyst_w + SUM_W'(1));
        go_down = (raw_idx < range_q) && (temp_w + hyst_w <= low_bound_w);
    end

    // Commit a new range on a tick with a trusted reading.
    always_ff @(posedge clk) begin
        if (!rst_n)
            range_q <= '0;
        else if (tick && temp_valid && (go_up || go_down))
            range_q <= raw_idx;
    end
endmodule

// File: rtl/tvc_slew.sv
// Step-wise slewer: on each tick moves the output code one step toward the
// target. Assumes the target is already clamped to the floor.
module tvc_slew
    import tvc_pkg::*;
#(
    parameter int VCODE_W    = 8,
    parameter int RESET_CODE = 112
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [VCODE_W-1:0] tgt,
    output logic [VCODE_W-1:0] code_q
);
    slew_dir_e dir;

    // Direction of the next step.
    always_comb dir = slew_dir(16'(code_q), 16'(tgt));

    // Issue at most one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= VCODE_W'(RESET_CODE);
        else if (tick) begin
            case (dir)
                SLEW_UP:   code_q <= code_q + 1'b1;
                SLEW_DOWN: code_q <= code_q - 1'b1;
                default:   code_q <= code_q;
            endcase
        end
    end
endmodule

// File: rtl/tvc_ctrl.sv
// Top of the temperature-indexed supply voltage controller. Ties together the
// tick divider, the per-frequency table, the range tracker and the slewer,
// and clamps the target to the floor. Assumes RESET_CODE >= FLOOR_CODE.
module tvc_ctrl #(
    parameter int NFREQ      = 4,
    parameter int NRANGE     = 8,
    parameter int TEMP_W     = 8,
    parameter int VCODE_W    = 8,
    parameter int HYST_W     = 4,
    parameter int TICK_W     = 16,
    parameter int FLOOR_CODE = 104,
    parameter int RESET_CODE = 112,
    localparam int FREQ_W    = (NFREQ  > 1) ? $clog2(NFREQ)  : 1,
    localparam int IDX_W     = (NRANGE > 1) ? $clog2(NRANGE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TICK_W-1:0]  tick_div,
    input  logic [HYST_W-1:0]  hyst_band,
    input  logic [TEMP_W-1:0]  temp,
    input  logic               temp_valid,
    input  logic [FREQ_W-1:0]  freq_sel,
    input  logic               wr_en,
    input  logic [FREQ_W-1:0]  wr_freq,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TEMP_W-1:0]  wr_bound,
    input  logic [VCODE_W-1:0] wr_code,
    output logic [VCODE_W-1:0] volt_code,
    output logic [VCODE_W-1:0] volt_tgt
);
    localparam logic [VCODE_W-1:0] FLOOR_V = VCODE_W'(FLOOR_CODE);

    logic                     tick;
    logic [IDX_W-1:0]         range_idx;
    logic [NRANGE*TEMP_W-1:0] bounds;
    logic [VCODE_W-1:0]       sel_code, cold_code, raw_tgt;

    tvc_tick_gen #(.TICK_W(TICK_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(tick_div), .tick(tick)
    );

    tvc_table #(
        .NFREQ(NFREQ), .NRANGE(NRANGE), .TEMP_W(TEMP_W),
        .VCODE_W(VCODE_W), .RESET_CODE(RESET_CODE)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_freq(wr_freq), .wr_idx(wr_idx),
        .wr_bound(wr_bound), .wr_code(wr_code),
        .rd_freq(freq_sel), .rd_idx(range_idx),
        .rd_bounds(bounds), .rd_code(sel_code), .rd_cold_code(cold_code)
    );

    tvc_range_sel #(.NRANGE(NRANGE), .TEMP_W(TEMP_W), .HYST_W(HYST_W)) u_range (
        .clk(clk), .rst_n(rst_n), .tick(tick), .temp_valid(temp_valid),
        .temp(temp), .hyst(hyst_band), .bounds(bounds), .range_q(range_idx)
    );

    // Choose the table target, falling back to the cold entry, then clamp to the floor.
    always_comb begin
        raw_tgt  = temp_valid ? sel_code : cold_code;
        volt_tgt = (raw_tgt < FLOOR_V) ? FLOOR_V : raw_tgt;
    end

    tvc_slew #(.VCODE_W(VCODE_W), .RESET_CODE(RESET_CODE)) u_slew (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tgt(volt_tgt), .code_q(volt_code)
    );
endmodule

// File: rtl/tvc_ctrl_chk.sv
// Property checker for tvc_ctrl, attached by bind below.
module tvc_ctrl_chk #(
    parameter int VCODE_W    = 8,
    parameter int IDX_W      = 3,
    parameter int FLOOR_CODE = 104
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               temp_valid,
    input logic [IDX_W-1:0]   range_idx,
    input logic [VCODE_W-1:0] volt_code,
    input logic [VCODE_W-1:0] volt_tgt
);
    a_r2_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_code != $past(volt_code)) |-> $past(tick));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_code != $past(volt_code)) |->
        ((volt_code - $past(volt_code)) == VCODE_W'(1) ||
         ($past(volt_code) - volt_code) == VCODE_W'(1)));

    a_r3_step_up_toward: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_code > $past(volt_code)) |-> ($past(volt_tgt) > $past(volt_code)));

    a_r3_step_down_toward: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_code < $past(volt_code)) |-> ($past(volt_tgt) < $past(volt_code)));

    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_code >= VCODE_W'(FLOOR_CODE)) && (volt_tgt >= VCODE_W'(FLOOR_CODE)));

    a_r8_hold_range: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(temp_valid) |-> (range_idx == $past(range_idx)));

    a_r10_hold_at_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(volt_code) == $past(volt_tgt)) |-> (volt_code == $past(volt_code)));
endmodule

bind tvc_ctrl tvc_ctrl_chk #(
    .VCODE_W(VCODE_W), .IDX_W(IDX_W), .FLOOR_CODE(FLOOR_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .temp_valid(temp_valid),
    .range_idx(range_idx), .volt_code(volt_code), .volt_tgt(volt_tgt)
);

// File: tb/test_tvc_ctrl.sv
// Scoreboard bench for tvc_ctrl: the driver queues expected codes, the monitor
// waits the settle time and compares at the falling edge.
module test_tvc_ctrl;
    localparam int PER = 4;  // tick_div + 1

    typedef struct {
        string tag;
        int    wait_cyc;
        int    exp_code;
        int    exp_tgt;
    } exp_t;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [15:0] tick_div = 16'(PER - 1);
    logic [3:0] hyst_band = '0;
    logic [7:0] temp = '0;
    logic       temp_valid = 0;
    logic [1:0] freq_sel = '0;
    logic       wr_en = 0;
    logic [1:0] wr_freq = '0;
    logic [2:0] wr_idx = '0;
    logic [7:0] wr_bound = '0;
    logic [7:0] wr_code = '0;
    logic [7:0] volt_code, volt_tgt;

    int   n_cmp = 0, n_bad = 0;
    int   n_push = 0, n_done = 0;
    int   cyc = 0, last_chg = -1, last_gap = 0, bad_steps = 0;
    logic [7:0] prev_code = '0;
    bit   finished = 0;
    exp_t q[$];

    tvc_ctrl i_tvc_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .hyst_band(hyst_band),
        .temp(temp), .temp_valid(temp_valid), .freq_sel(freq_sel),
        .wr_en(wr_en), .wr_freq(wr_freq), .wr_idx(wr_idx),
        .wr_bound(wr_bound), .wr_code(wr_code),
        .volt_code(volt_code), .volt_tgt(volt_tgt)
    );

    always #2 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Queue an expectation and block until the monitor has compared it.
    task automatic expect_after(string tag, int wait_cyc, int code, int tgt);
        exp_t e;
        e.tag = tag; e.wait_cyc = wait_cyc; e.exp_code = code; e.exp_tgt = tgt;
        q.push_back(e);
        n_push++;
        wait (n_done == n_push);
    endtask

    function automatic int settle(int steps);
        return (steps + 3) * PER;
    endfunction

    task automatic wr(int f, int i, int b, int c);
        @(negedge clk);
        wr_en = 1; wr_freq = 2'(f); wr_idx = 3'(i); wr_bound = 8'(b); wr_code = 8'(c);
        @(negedge clk);
        wr_en = 0;
    endtask

    // Monitor: pop, wait the settle time, compare away from the rising edge.
    initial begin
        forever begin
            exp_t e;
            wait (n_push > n_done);
            e = q.pop_front();
            repeat (e.wait_cyc) @(negedge clk);
            #1;
            check({e.tag, " code"}, int'(volt_code), e.exp_code);
            check({e.tag, " target"}, int'(volt_tgt), e.exp_tgt);
            n_done++;
        end
    end

    // Step monitor: size of each code change and spacing between changes.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (volt_code != prev_code) begin
                if ((volt_code - prev_code != 8'd1) && (prev_code - volt_code != 8'd1))
                    bad_steps <= bad_steps + 1;
                if (last_chg >= 0) last_gap <= cyc - last_chg;
                last_chg <= cyc;
            end
        end
        prev_code <= volt_code;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        expect_after("R1 reset", 0, 112, 112);

        // R9 load: freq 0 uses bounds 10/30/50/70/255, freq 1 ends below the floor.
        wr(0, 0, 10, 112); wr(0, 1, 30, 110); wr(0, 2, 50, 109);
        wr(0, 3, 70, 107); wr(0, 4, 255, 106);
        wr(1, 0, 10, 140); wr(1, 1, 30, 138); wr(1, 2, 50, 136);
        wr(1, 3, 70, 134); wr(1, 4, 255, 100);
        expect_after("R8 invalid after load", 4 * PER, 112, 112);

        @(negedge clk); temp = 8'd25; temp_valid = 1;
        expect_after("R4 range1", settle(2), 110, 110);
        @(negedge clk); temp = 8'd65;
        expect_after("R4 range3", settle(3), 107, 107);
        @(negedge clk); temp = 8'd200;
        expect_after("R4 last range", settle(1), 106, 106);
        @(negedge clk); freq_sel = 2'd1;
        expect_after("R6 floor clamp", settle(2), 104, 104);
        @(negedge clk); temp = 8'd20;
        expect_after("R5 table1 range1", settle(34), 138, 138);
        check("R2 step spacing", last_gap, PER);
        expect_after("R10 hold at target", 20, 138, 138);

        @(negedge clk); freq_sel = 2'd0; hyst_band = 4'd5;
        expect_after("R5 back to table0", settle(28), 110, 110);
        @(negedge clk); temp = 8'd33;
        expect_after("R7 inside band up", settle(1), 110, 110);
        @(negedge clk); temp = 8'd37;
        expect_after("R7 clears band up", settle(1), 109, 109);
        @(negedge clk); temp = 8'd28;
        expect_after("R7 inside band down", settle(1), 109, 109);
        @(negedge clk); temp = 8'd24;
        expect_after("R7 clears band down", settle(1), 110, 110);

        @(negedge clk); temp_valid = 0; temp = 8'd200;
        expect_after("R8 invalid cold target", settle(2), 112, 112);
        @(negedge clk); temp = 8'd35; temp_valid = 1;
        expect_after("R8 range held", settle(2), 110, 110);

        wr(0, 1, 30, 111);
        expect_after("R9 rewrite live entry", settle(1), 111, 111);

        check("R3 step size", bad_steps, 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule